// File: doc/BRIEF.md
# Power Management Control/Status Register with Downstream Gating

This block is a configuration-space control/status dword for the power management capability of a bridge-like function. Software reads and writes it through configuration accesses that carry a byte address and four byte enables. The dword holds a two-bit device power state and a PME enable bit. The PME enable bit is sticky and survives a function reset. Every other bit reads as zero.

The stored power state drives three gating outputs. While the function is in any state other than fully on, interrupts and memory-mapped register responses are blocked. Downstream cycles are flagged for master abort in that case too, except type-0 configuration cycles, which are still claimed. The two intermediate power states are not supported. A write asking for one of them completes, but it changes nothing.

Top module: `pm_state_reg`

## Requirements
- R1: After power-on reset, the power state is D0 (code 00), the PME enable bit is 0, and a read of the register returns 00000000h.
- R2: A write that hits the register (byte address 84h, dword bits of the address compared) with byte enable 0 set and data bits 1:0 equal to 00 (D0) or 11 (D3) stores that code. The code reads back at bits 1:0 from the next cycle.
- R3: A write of code 01 or 10 to bits 1:0 leaves the stored power state unchanged.
- R4: With byte enable 0 clear, a write does not change the power state, whatever the data bits 1:0 hold.
- R5: A hitting write with byte enable 1 set stores data bit 8 as the PME enable bit, which reads back at bit 8.
- R6: A function reset sets the power state to D0 but keeps the PME enable bit. Only the power-on reset clears the PME enable bit.
- R7: Read data bits 31:9 and 7:2 are always zero, even after writes of all ones.
- R8: A read returns the register in the same cycle as the request. An access to any other dword address reads as zero, and a write to it changes nothing.
- R9: `intBlock` and `mmioBlock` are high exactly while the stored state is not D0.
- R10: `dsMasterAbort` is high exactly when `dsReq` is high, the stored state is not D0, and `dsCfgType0` is low.
- R11: Writing D0 from D3 removes all gating from the next cycle, with no further sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, clears all state |
| fnRstN | input | 1 | Function reset, active low, clears non-sticky state |
| cfgReq | input | 1 | Configuration access valid |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgAddr | input | 8 | Configuration byte address |
| cfgByteEn | input | 4 | Byte lane enables for the write |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, combinational |
| dsReq | input | 1 | A downstream cycle is presented |
| dsCfgType0 | input | 1 | The presented cycle is a type-0 configuration cycle |
| dsMasterAbort | output | 1 | The downstream cycle is not claimed |
| intBlock | output | 1 | Interrupt generation is blocked |
| mmioBlock | output | 1 | Memory-mapped responses are blocked |

## Verification
The state is only two bits and one bit, and each is mirrored at the ports without delay. A wrongly accepted intermediate code or a missed lane-0 write therefore appears both in the readback and on the gating outputs in the cycle after the write. A sticky bit cleared by the wrong reset shows at bit 8 on the first read after that reset. A bad abort decode shows in the same cycle that a downstream request is applied.

// File: rtl/pmreg_pkg.sv
package pmreg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int BE_W = DATA_W / 8;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwrState_t;

  localparam int PS_LSB = 0;
  localparam int PME_BIT = 8;

  typedef struct packed {
    logic      psWrite;
    pwrState_t psNext;
    logic      pmeWrite;
    logic      pmeNext;
    logic      rdEn;
  } pmStrobes_t;

  function automatic logic psSupported(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3);
  endfunction
endpackage

// File: rtl/pmreg_ctrl.sv
module pmreg_ctrl
  import pmreg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter logic [AW-1:0] REG_OFS = 8'h84
) (
  input  logic          cfgReq,
  input  logic          cfgWrite,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW/8-1:0] cfgByteEn,
  input  logic [DW-1:0] cfgWdata,
  output pmStrobes_t    strb
);
  localparam int LANE_PS = PS_LSB / 8;
  localparam int LANE_PME = PME_BIT / 8;

  logic hit;
  logic wrHit;
  logic [1:0] reqCode;

  assign hit = cfgReq && (cfgAddr[AW-1:2] == REG_OFS[AW-1:2]);
  assign wrHit = hit && cfgWrite;
  assign reqCode = cfgWdata[PS_LSB +: 2];

  always_comb begin
    strb = '0;
    strb.rdEn = hit && !cfgWrite;
    strb.psNext = pwrState_t'(reqCode);
    strb.psWrite = wrHit && cfgByteEn[LANE_PS] && psSupported(reqCode);
    strb.pmeNext = cfgWdata[PME_BIT];
    strb.pmeWrite = wrHit && cfgByteEn[LANE_PME];
  end

  // R4: without lane 0 enabled, the state strobe never fires
  always_comb begin
    if (!cfgByteEn[LANE_PS])
      p_lane0_needed_r4: assert (!strb.psWrite);
  end

  // R8: reads and writes are exclusive
  always_comb begin
    p_rd_wr_excl_r8: assert (!(strb.rdEn && (strb.psWrite || strb.pmeWrite)));
  end
endmodule

// File: rtl/pmreg_datapath.sv
module pmreg_datapath
  import pmreg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          fnRstN,
  input  pmStrobes_t    strb,
  input  logic          dsReq,
  input  logic          dsCfgType0,
  output logic [DW-1:0] rdData,
  output logic          dsMasterAbort,
  output logic          intBlock,
  output logic          mmioBlock
);
  pwrState_t curState;
  logic      pmeEn;
  logic      stateRstN;
  logic      notOn;
  logic [DW-1:0] regImage;

  assign stateRstN = porRstN & fnRstN;

  always_ff @(posedge clk or negedge stateRstN) begin
    if (!stateRstN) curState <= PS_D0;
    else if (strb.psWrite) curState <= strb.psNext;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) pmeEn <= 1'b0;
    else if (strb.pmeWrite) pmeEn <= strb.pmeNext;
  end

  always_comb begin
    regImage = '0;
    regImage[PS_LSB +: 2] = curState;
    regImage[PME_BIT] = pmeEn;
  end

  assign rdData = strb.rdEn ? regImage : '0;

  assign notOn = (curState != PS_D0);
  assign intBlock = notOn;
  assign mmioBlock = notOn;
  assign dsMasterAbort = dsReq && notOn && !dsCfgType0;

  // R3: stored state never holds an unsupported code
  always_comb begin
    if (stateRstN)
      p_state_legal_r3: assert (psSupported(curState));
  end

  p_no_spurious_change_r4: assert property (@(posedge clk) disable iff (!stateRstN)
    !strb.psWrite |=> $stable(curState));

  p_pme_hold_r5: assert property (@(posedge clk) disable iff (!porRstN)
    !strb.pmeWrite |=> $stable(pmeEn));

  p_type0_claimed_r10: assert property (@(posedge clk) disable iff (!stateRstN)
    dsCfgType0 |-> !dsMasterAbort);

  p_d0_unblocked_r9: assert property (@(posedge clk) disable iff (!stateRstN)
    (strb.psWrite && strb.psNext == PS_D0) |=> (!intBlock && !mmioBlock && !dsMasterAbort));

  // R7: reserved bits of the readback are zero
  always_comb begin
    p_reserved_zero_r7: assert (rdData[DW-1:PME_BIT+1] == '0 && rdData[PME_BIT-1:2] == '0);
  end
endmodule

// File: rtl/pm_state_reg.sv
module pm_state_reg
  import pmreg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter logic [AW-1:0] REG_OFS = 8'h84
) (
  input  logic            clk,
  input  logic            porRstN,
  input  logic            fnRstN,
  input  logic            cfgReq,
  input  logic            cfgWrite,
  input  logic [AW-1:0]   cfgAddr,
  input  logic [DW/8-1:0] cfgByteEn,
  input  logic [DW-1:0]   cfgWdata,
  output logic [DW-1:0]   cfgRdata,
  input  logic            dsReq,
  input  logic            dsCfgType0,
  output logic            dsMasterAbort,
  output logic            intBlock,
  output logic            mmioBlock
);
  pmStrobes_t strb;

  pmreg_ctrl #(.AW(AW), .DW(DW), .REG_OFS(REG_OFS)) u_ctrl (
    .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata), .strb(strb)
  );

  pmreg_datapath #(.DW(DW)) u_dp (
    .clk(clk), .porRstN(porRstN), .fnRstN(fnRstN), .strb(strb),
    .dsReq(dsReq), .dsCfgType0(dsCfgType0), .rdData(cfgRdata),
    .dsMasterAbort(dsMasterAbort), .intBlock(intBlock), .mmioBlock(mmioBlock)
  );
endmodule

// File: tb/sim_pm_state_reg.sv
`timescale 1ns/1ps
module sim_pm_state_reg;
  logic clk = 1'b0;
  logic porRstN, fnRstN, cfgReq, cfgWrite, dsReq, dsCfgType0;
  logic [7:0] cfgAddr;
  logic [3:0] cfgByteEn;
  logic [31:0] cfgWdata, cfgRdata;
  logic dsMasterAbort, intBlock, mmioBlock;
  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  pm_state_reg u0 (.*);

  // vector: {byteEn, wdata, expected state, expected pme}
  localparam int NV = 9;
  localparam logic [38:0] VEC [NV] = '{
    {4'h1, 32'h0000_0003, 2'b11, 1'b0},  // R2 go to D3
    {4'h1, 32'h0000_0001, 2'b11, 1'b0},  // R3 D1 dropped
    {4'h1, 32'h0000_0002, 2'b11, 1'b0},  // R3 D2 dropped
    {4'hE, 32'h0000_0000, 2'b11, 1'b0},  // R4 lane 0 off
    {4'h2, 32'h0000_0100, 2'b11, 1'b1},  // R5 pme set
    {4'hF, 32'hFFFF_FFFC, 2'b00, 1'b1},  // R7 all ones elsewhere
    {4'h1, 32'h0000_0003, 2'b11, 1'b1},  // R2 D3 again
    {4'hF, 32'h0000_0000, 2'b00, 1'b0},  // R11 back to D0
    {4'h3, 32'h0000_0103, 2'b11, 1'b1}   // R2 R5 both lanes
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfgReq = 0; cfgWrite = 0; cfgAddr = 8'h84; cfgByteEn = 0; cfgWdata = 0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgReq = 1; cfgWrite = 1; cfgAddr = a; cfgByteEn = be; cfgWdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    cfgReq = 1; cfgWrite = 0; cfgAddr = a;
    #1;
    check(req, cfgRdata, exp);
    idle();
  endtask

  task automatic gateCheck(input string req, input logic on);
    dsReq = 1; dsCfgType0 = 0; #0.2;
    check(req, {29'b0, intBlock, mmioBlock, dsMasterAbort}, on ? 32'h0 : 32'h7);
    dsCfgType0 = 1; #0.2;
    check({req, " type0"}, {31'b0, dsMasterAbort}, 32'h0);
    dsReq = 0; dsCfgType0 = 0; #0.2;
    check({req, " no req"}, {31'b0, dsMasterAbort}, 32'h0);
  endtask

  initial begin
    #20000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    idle(); dsReq = 0; dsCfgType0 = 0;
    porRstN = 0; fnRstN = 0;
    repeat (3) @(negedge clk);
    porRstN = 1; fnRstN = 1;
    @(negedge clk);
    readCheck("R1 reset value", 8'h84, 32'h0);
    gateCheck("R1 R9 reset gating", 1'b1);

    for (int i = 0; i < NV; i++) begin
      doWrite(8'h84, VEC[i][38:35], VEC[i][34:3]);
      readCheck($sformatf("vector %0d R2 R3 R4 R5 R7", i), 8'h84,
                {23'b0, VEC[i][0], 6'b0, VEC[i][2:1]});
      gateCheck($sformatf("vector %0d R9 R10 R11", i), VEC[i][2:1] == 2'b00);
    end

    // R8: other address ignored and reads zero; state is D3, pme 1
    doWrite(8'h88, 4'hF, 32'h0);
    readCheck("R8 other address reads zero", 8'h88, 32'h0);
    readCheck("R8 write elsewhere ignored", 8'h86, 32'h0000_0103);

    // R6: function reset keeps pme, clears state
    @(negedge clk); fnRstN = 0;
    @(negedge clk); fnRstN = 1;
    @(negedge clk);
    readCheck("R6 fn reset keeps sticky", 8'h84, 32'h0000_0100);
    gateCheck("R6 R9 after fn reset", 1'b1);

    // R1: power-on reset clears pme
    @(negedge clk); porRstN = 0;
    @(negedge clk); porRstN = 1;
    @(negedge clk);
    readCheck("R1 R6 por clears sticky", 8'h84, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule